// File: doc/BRIEF.md
# Card Bus Clock Divider and Gate

This block derives the clock driven to a memory card from a fixed reference. The block runs on a clock at twice the reference frequency, so the reference itself is one half of the block clock. A 3-bit exponent `e` sets the card clock to the reference divided by 2^e, for ratios from 1 to 128. The divided clock is a register output. Each of its high and low phases lasts exactly 2^e block-clock cycles.

Software drives the block through a narrow control strobe word and a separate rate-write port. It reads back a 16-bit status word. Control bits can request a clock stop, a clock start, a one-cycle start-operation pulse for the command engine, or a soft reset of the block. Stop, start and rate changes take effect only on divided-clock boundaries. This means no shortened high pulse ever reaches the card. Software polls the running flag and waits for it to drop before it changes any command setup.

Top module: `card_clk_gen`

## Requirements
- R1: While running with exponent `e`, `card_clk_o` alternates high and low phases of exactly 2^e block-clock cycles each (card clock = reference / 2^e, reference = block clock / 2).
- R2: A rate write stores `rate_wdata_i` in the pending rate, which reads back on `rate_rd_o` from the cycle after the write.
- R3: Control bit 0 requests a stop. If the clock is low, it stops at once. If the clock is high, it first completes the full high phase. Status bit 8 falls in the same cycle the clock is held low, and the clock then stays low.
- R4: Control bit 1 starts a stopped clock. Status bit 8 reads 1 from the cycle after the write, and the first rising edge follows a full low phase of 2^e cycles.
- R5: When bits 0 and 1 are written together, the stop request wins and a stopped clock stays stopped.
- R6: A rate written while the clock is running takes effect only after the falling edge that ends the current period. That period completes with the old ratio, and the next low phase already uses the new ratio.
- R7: Control bit 2 produces a one-cycle pulse on `start_op_o` in the cycle after the write. It may be combined with bit 1.
- R8: Control bit 3 starts a soft reset. Status bit 15 reads 1 for RST_CYCLES cycles. The clock is forced low and stopped, and the rate returns to 0. Rate and control writes made while status bit 15 is set have no effect.
- R9: After the hardware reset, the status word is 0, `card_clk_o` is low, `rate_rd_o` is 0 and `start_op_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, twice the reference frequency |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 4 | Control word: bit0 stop, bit1 start, bit2 start-op, bit3 soft reset |
| rate_we_i | input | 1 | Rate write strobe |
| rate_wdata_i | input | 3 | Division exponent e |
| card_clk_o | output | 1 | Divided, gated card clock |
| start_op_o | output | 1 | One-cycle start-operation pulse |
| status_o | output | 16 | Bit 8 clock running, bit 15 reset in progress, others 0 |
| rate_rd_o | output | 3 | Pending rate exponent |

## Verification
The bench measures phase widths at several exponents, including ratio 1 and the largest ratio. A wrong mask or counter limit would show as a phase of the wrong length. It issues a stop during a high phase. A design that gated at once would cut the pulse short. It also issues a stop during a low phase, where a design that waits for the next boundary would leave the running flag high for too long.

The bench changes the rate in the middle of a period, and a design that latches the rate early would shorten the current high phase. It writes stop and start together, and a design with the wrong priority would start the clock. It writes rate and control words during a soft reset, and a leaky mask would show as a non-zero rate or a running clock once the reset ends.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int RATE_W  = 3;
  localparam int MAX_EXP = (1 << RATE_W) - 1;
  localparam int CNT_W   = MAX_EXP;
  localparam int CTL_W   = 4;
  localparam int STAT_W  = 16;

  localparam int CTL_STOP  = 0;
  localparam int CTL_START = 1;
  localparam int CTL_OP    = 2;
  localparam int CTL_RST   = 3;

  localparam int ST_RUN = 8;
  localparam int ST_RST = 15;

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Last count value of one half period: 2^e - 1.
  function automatic cnt_t half_last(input rate_t e);
    logic [CNT_W:0] one_hot;
    one_hot = (CNT_W+1)'(1) << e;
    return CNT_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/ccg_ctl_decode.sv
module ccg_ctl_decode
  import ccg_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             rate_we_i,
  input  rate_t            rate_wdata_i,
  output logic             stop_wr_o,
  output logic             start_wr_o,
  output logic             clear_o,
  output logic             resetting_o,
  output logic             start_op_o,
  output rate_t            pend_rate_o,
  output rate_t            next_rate_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  logic [RC_W-1:0] rst_cnt_q;
  logic            reset_now;
  logic            wr_ok;
  logic            op_q;
  rate_t           pend_q;

  assign reset_now   = ctl_we_i & ctl_wdata_i[CTL_RST];
  assign resetting_o = (rst_cnt_q != '0);
  assign clear_o     = resetting_o | reset_now;
  assign wr_ok       = ctl_we_i & ~clear_o;

  assign stop_wr_o  = wr_ok & ctl_wdata_i[CTL_STOP];
  assign start_wr_o = wr_ok & ctl_wdata_i[CTL_START] & ~ctl_wdata_i[CTL_STOP];

  assign next_rate_o = (rate_we_i && !clear_o) ? rate_wdata_i : pend_q;
  assign pend_rate_o = pend_q;
  assign start_op_o  = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt_q <= '0;
      pend_q    <= '0;
      op_q      <= 1'b0;
    end else begin
      if (reset_now)        rst_cnt_q <= RC_W'(RST_CYCLES);
      else if (resetting_o) rst_cnt_q <= rst_cnt_q - 1'b1;
      pend_q <= clear_o ? '0 : next_rate_o;
      op_q   <= wr_ok & ctl_wdata_i[CTL_OP];
    end
  end

  AST_OP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_op_o |-> $past(ctl_we_i && ctl_wdata_i[CTL_OP])); // R7
  AST_RATE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resetting_o && $past(clear_o)) |-> (pend_rate_o == '0)); // R8
endmodule

// File: rtl/ccg_divider.sv
module ccg_divider
  import ccg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hold_i,
  input  rate_t rate_i,
  output logic  tick_o
);
  cnt_t cnt_q;

  assign tick_o = (cnt_q == half_last(rate_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hold_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= half_last(rate_i)); // R1
endmodule

// File: rtl/ccg_gate.sv
module ccg_gate
  import ccg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  stop_wr_i,
  input  logic  start_wr_i,
  input  rate_t next_rate_i,
  input  logic  tick_i,
  output logic  running_o,
  output logic  card_clk_o,
  output rate_t active_rate_o,
  output logic  period_end_o
);
  logic  running_q, clk_q, stop_pend_q;
  rate_t rate_q;
  logic  stop_req;

  assign stop_req      = stop_pend_q | stop_wr_i;
  assign period_end_o  = running_q & clk_q & tick_i;
  assign running_o     = running_q;
  assign card_clk_o    = clk_q;
  assign active_rate_o = rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q   <= 1'b0;
      clk_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      rate_q      <= '0;
    end else if (clear_i) begin
      running_q   <= 1'b0;
      clk_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      rate_q      <= '0;
    end else if (running_q) begin
      if (stop_req && !clk_q) begin
        running_q   <= 1'b0;
        stop_pend_q <= 1'b0;
      end else if (stop_req && tick_i) begin
        running_q   <= 1'b0;
        clk_q       <= 1'b0;
        stop_pend_q <= 1'b0;
        rate_q      <= next_rate_i;
      end else begin
        if (tick_i)       clk_q  <= ~clk_q;
        if (period_end_o) rate_q <= next_rate_i;
        stop_pend_q <= stop_wr_i | (stop_pend_q & ~start_wr_i);
      end
    end else begin
      rate_q      <= next_rate_i;
      stop_pend_q <= 1'b0;
      if (start_wr_i) running_q <= 1'b1;
    end
  end

  AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_q) |-> !clk_q); // R3
  AST_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_q) |-> ($past(tick_i) || $past(clear_i))); // R1
  AST_RATE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && $past(running_q) && !$past(period_end_o) && !$past(clear_i))
      |-> $stable(rate_q)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (!running_q && !clk_q)); // R8
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen
  import ccg_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_wdata_i,
  output logic              card_clk_o,
  output logic              start_op_o,
  output logic [STAT_W-1:0] status_o,
  output logic [RATE_W-1:0] rate_rd_o
);
  logic  stop_wr, start_wr, clear, resetting;
  logic  running, tick, period_end;
  rate_t pend_rate, next_rate, active_rate;

  ccg_ctl_decode #(.RST_CYCLES(RST_CYCLES)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctl_we_i     (ctl_we_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .rate_we_i    (rate_we_i),
    .rate_wdata_i (rate_wdata_i),
    .stop_wr_o    (stop_wr),
    .start_wr_o   (start_wr),
    .clear_o      (clear),
    .resetting_o  (resetting),
    .start_op_o   (start_op_o),
    .pend_rate_o  (pend_rate),
    .next_rate_o  (next_rate)
  );

  ccg_divider u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (~running | clear),
    .rate_i (active_rate),
    .tick_o (tick)
  );

  ccg_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clear),
    .stop_wr_i     (stop_wr),
    .start_wr_i    (start_wr),
    .next_rate_i   (next_rate),
    .tick_i        (tick),
    .running_o     (running),
    .card_clk_o    (card_clk_o),
    .active_rate_o (active_rate),
    .period_end_o  (period_end)
  );

  assign rate_rd_o = pend_rate;

  always_comb begin
    status_o         = '0;
    status_o[ST_RUN] = running;
    status_o[ST_RST] = resetting;
  end

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[CTL_STOP] && !card_clk_o) |=> !status_o[ST_RUN]); // R5
  AST_RESET_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_RST] |-> (!status_o[ST_RUN] && !card_clk_o)); // R8
endmodule

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic       rate_we = 1'b0;
  logic [2:0] rate_wdata = '0;
  logic       card_clk, start_op;
  logic [15:0] status;
  logic [2:0] rate_rd;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  card_clk_gen #(.RST_CYCLES(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .rate_we_i(rate_we), .rate_wdata_i(rate_wdata), .card_clk_o(card_clk),
    .start_op_o(start_op), .status_o(status), .rate_rd_o(rate_rd)
  );

  // rate exponent, expected phase length in block cycles
  localparam int VEC_N = 6;
  localparam int VEC [VEC_N][2] = '{'{0, 1}, '{3, 8}, '{1, 2}, '{7, 128}, '{2, 4}, '{5, 32}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wr_rate(input logic [2:0] v);
    rate_wdata = v; rate_we = 1'b1;
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  task automatic count_level(input logic v, output int n);
    n = 0;
    while (card_clk == v && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_stopped();
    for (int i = 0; i < 400 && status[8]; i++) @(negedge clk);
  endtask

  task automatic wait_high();
    for (int i = 0; i < 400 && !card_clk; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lo, hi, lo2, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 status", int'(status), 0);
    check("R9 card_clk", int'(card_clk), 0);
    check("R9 rate_rd", int'(rate_rd), 0);
    check("R9 start_op", int'(start_op), 0);

    // R1 / R2 / R4 vector walk
    for (int v = 0; v < VEC_N; v++) begin
      wr_rate(3'(VEC[v][0]));
      check("R2 rate readback", int'(rate_rd), VEC[v][0]);
      wr_ctl(4'b0010);
      check("R4 running after start", int'(status[8]), 1);
      count_level(1'b0, lo);
      count_level(1'b1, hi);
      count_level(1'b0, lo2);
      check("R4 first low phase", lo, VEC[v][1]);
      check("R1 high phase", hi, VEC[v][1]);
      check("R1 low phase", lo2, VEC[v][1]);
      wr_ctl(4'b0001);
      wait_stopped();
      check("R3 stopped low", int'(card_clk), 0);
    end

    // R3 stop during high phase completes the pulse
    wr_rate(3'd3);
    wr_ctl(4'b0010);
    wait_high();
    hi = 1;
    ctl_wdata = 4'b0001; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
    n = 0;
    while (card_clk && n < 100) begin
      if (!status[8]) n = 1000;
      hi++; n++;
      @(negedge clk);
    end
    check("R3 full high before stop", hi, 8);
    check("R3 status falls with clock", int'(status[8]), 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (card_clk) n++;
      @(negedge clk);
    end
    check("R3 stays low", n, 0);

    // R3 stop during low phase is immediate
    wr_rate(3'd2);
    wr_ctl(4'b0010);
    wr_ctl(4'b0001);
    check("R3 low-phase stop", int'(status[8]), 0);
    check("R3 low-phase clk", int'(card_clk), 0);

    // R5 stop and start together
    wr_ctl(4'b0011);
    check("R5 stop wins", int'(status[8]), 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (card_clk) n++;
      @(negedge clk);
    end
    check("R5 no pulses", n, 0);

    // R6 rate change mid-period
    wr_rate(3'd1);
    wr_ctl(4'b0010);
    wait_high();
    hi = 1;
    wr_rate(3'd2);
    check("R2 new rate readback", int'(rate_rd), 2);
    count_level(1'b1, n);
    hi += n;
    count_level(1'b0, lo);
    count_level(1'b1, lo2);
    check("R6 old high kept", hi, 2);
    check("R6 new low", lo, 4);
    check("R6 new high", lo2, 4);
    wr_ctl(4'b0001);
    wait_stopped();

    // R7 start-op strobe with start
    ctl_wdata = 4'b0110; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
    check("R7 pulse", int'(start_op), 1);
    check("R7 combined start", int'(status[8]), 1);
    @(negedge clk);
    check("R7 pulse one cycle", int'(start_op), 0);
    wr_ctl(4'b0001);
    wait_stopped();

    // R8 soft reset length and effect
    wr_rate(3'd4);
    wr_ctl(4'b0010);
    repeat (20) @(negedge clk);
    wr_ctl(4'b1000);
    check("R8 clock forced low", int'(card_clk), 0);
    check("R8 running cleared", int'(status[8]), 0);
    check("R8 rate cleared", int'(rate_rd), 0);
    n = 0;
    while (status[15] && n < 50) begin
      n++;
      @(negedge clk);
    end
    check("R8 reset length", n, 4);

    // R8 writes ignored during reset
    wr_ctl(4'b1000);
    wr_rate(3'd5);
    wr_ctl(4'b0010);
    check("R8 rate write ignored", int'(rate_rd), 0);
    repeat (4) @(negedge clk);
    check("R8 reset ended", int'(status[15]), 0);
    check("R8 start ignored", int'(status[8]), 0);
    check("R8 rate still zero", int'(rate_rd), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule